// File: doc/BRIEF.md
# Device Configuration Header Register File

This block keeps the 256-byte configuration header of one device and serves it through a plain register port. Each access gives a byte offset, a size (byte, word or dword), a write flag and write data. A read returns its data one clock after the strobe, zero-extended and little-endian. When an access would run past the end of the space, the read narrows to fewer bytes. A write is applied byte by byte under a protection map. The header-type byte selects which map applies.

An aligned dword write to a base address register whose region is implemented takes a separate path. The block clears the address bits inside the region size and forces the region's type bits in. The expansion ROM register keeps its enable bit instead. When a base register is written, or when a write touches the command word, the block pulses a single-cycle update output so that a downstream address-window decoder can recompute its windows. A bridge variant, selected by a parameter, also captures the secondary bus number from writes at the bus-number bytes.

Top module: `cfg_space_regs`

## Requirements
- R1: After reset, bytes 0x00-0x01 hold VENDOR_ID, 0x02-0x03 hold DEVICE_ID, 0x08-0x0B hold CLASS_REV (low byte first), 0x0E holds HDR_TYPE and 0x3D holds INT_PIN. The low byte of each implemented base register (offset 0x10 + 4*i, i = 0..5) holds that region's type bits. Every other byte is zero, and sec_bus and map_update are 0.
- R2: A read (req_valid=1, req_write=0) loads rd_data on the next clock edge, and rd_data holds its value otherwise. req_size encodes 0 = byte, 1 = word, 2 or 3 = dword. A dword read returns 4 bytes if the offset is at most 0xFC. A word or dword read that is not served as 4 bytes returns 2 bytes if the offset is at most 0xFE. Every other read returns 1 byte. The lowest offset goes to bits 7:0 and the unused upper bits are zero.
- R3: When the header-type byte is 0x00 or 0x80, ordinary writes leave bytes 0x00-0x03, 0x08-0x0B, 0x0E, 0x10-0x27, 0x30-0x33 and 0x3D unchanged. All other bytes take the written data.
- R4: For any other header-type value (a bridge header), ordinary writes leave bytes 0x00-0x03, 0x08-0x0B, 0x0E, 0x38-0x3B and 0x3D unchanged. All other bytes take the written data.
- R5: A dword write at offset 0x10 + 4*i (i = 0..5) for a region with nonzero REGION_LOG2 stores the data with its low REGION_LOG2 bits cleared, then ORed with that region's 4-bit REGION_TYPE. This happens whatever the protection map says.
- R6: A dword write at offset 0x30 for a ROM slot (index 6) with nonzero size keeps the bits at or above REGION_LOG2, keeps bit 0, and clears all other bits.
- R7: A dword write at a base or ROM offset whose region size is zero follows the ordinary byte-wise path of R3/R4.
- R8: Ordinary writes of 2 or 4 bytes update successive offsets from the start offset upward. Bytes beyond 0xFF are dropped and never wrap to offset 0x00.
- R9: With BRIDGE=1, a write at offset 0x19 (any size) sets sec_bus to data bits 7:0. A word or dword write at 0x18 sets sec_bus to data bits 15:8. No other write changes it. With BRIDGE=0, sec_bus stays 0.
- R10: map_update is high for exactly the cycle after a write that took the base/ROM path of R5/R6, or a write whose byte span covers offset 0x04 or 0x05. It is low in every other cycle.
- R11: A dword write at an offset in the base or ROM range that is not 4-byte aligned follows the ordinary byte-wise path.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Access strobe, one cycle per access |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 8 | Byte offset in configuration space |
| req_size | input | 2 | 0 byte, 1 word, 2/3 dword |
| req_wdata | input | 32 | Write data, lowest offset in bits 7:0 |
| rd_data | output | 32 | Read data, valid the cycle after a read strobe |
| sec_bus | output | 8 | Captured secondary bus number (bridge variant) |
| map_update | output | 1 | One-cycle pulse requesting a window recompute |

## Verification
The bench builds two instances side by side. The first is an endpoint with header type 0x00. It has an I/O region of 32 bytes, a prefetchable memory region of 4 KiB, a 1 MiB memory region, three empty base slots and a 2 KiB ROM. The second is a bridge with header type 0x81, one 64 KiB memory region and no ROM. With this pair, both protection maps, masking for I/O, memory and ROM, and the zero-size fallback can all be reached. Every byte offset gets a read sweep and a byte-write sweep against both maps, and every read width is tried at the tail offsets 0xF0-0xFF. The bridge also brings the secondary-bus capture cases into reach.

// File: rtl/cfgspc_pkg.sv
package cfgspc_pkg;
  localparam int unsigned CFG_BYTES   = 256;
  localparam int unsigned NUM_REGIONS = 7;
  localparam int unsigned NUM_BARS    = 6;
  localparam int unsigned ROM_SLOT    = 6;
  localparam int unsigned LOG2_W      = 6;
  localparam int unsigned TYPE_W      = 4;

  localparam logic [1:0] SZ_BYTE = 2'd0;
  localparam logic [1:0] SZ_WORD = 2'd1;

  // number of bytes an access spans
  function automatic logic [2:0] size_bytes(input logic [1:0] sz);
    logic [2:0] n;
    case (sz)
      SZ_BYTE: n = 3'd1;
      SZ_WORD: n = 3'd2;
      default: n = 3'd4;
    endcase
    return n;
  endfunction

  // protection map chosen by the header-type byte
  function automatic logic byte_writable(input logic [7:0] hdr, input logic [7:0] a);
    logic locked_common;
    logic locked_map;
    locked_common = (a <= 8'h03) || (a >= 8'h08 && a <= 8'h0B) ||
                    (a == 8'h0E) || (a == 8'h3D);
    if (hdr == 8'h00 || hdr == 8'h80)
      locked_map = (a >= 8'h10 && a <= 8'h27) || (a >= 8'h30 && a <= 8'h33);
    else
      locked_map = (a >= 8'h38 && a <= 8'h3B);
    return !(locked_common || locked_map);
  endfunction
endpackage

// File: rtl/cfg_bar_mask.sv
module cfg_bar_mask
  import cfgspc_pkg::*;
#(
  parameter logic [NUM_REGIONS*LOG2_W-1:0] REGION_LOG2 = '0,
  parameter logic [NUM_REGIONS*TYPE_W-1:0] REGION_TYPE = '0
) (
  input  logic [7:0]  addr,
  input  logic [1:0]  size,
  input  logic [31:0] wdata,
  output logic        hit,
  output logic [31:0] value
);
  logic              slot_ok;
  logic [2:0]        slot;
  logic [LOG2_W-1:0] lg;
  logic [TYPE_W-1:0] ty;
  logic [31:0]       keep;

  always_comb begin
    slot_ok = 1'b0;
    slot    = '0;
    if (addr[1:0] == 2'b00) begin
      if (addr >= 8'h10 && addr <= 8'h24) begin
        slot_ok = 1'b1;
        slot    = 3'(addr[7:2] - 6'h04);
      end else if (addr == 8'h30) begin
        slot_ok = 1'b1;
        slot    = 3'(ROM_SLOT);
      end
    end
    lg = '0;
    ty = '0;
    for (int i = 0; i < NUM_REGIONS; i++) begin
      if (slot == 3'(i)) begin
        lg = REGION_LOG2[i*LOG2_W +: LOG2_W];
        ty = REGION_TYPE[i*TYPE_W +: TYPE_W];
      end
    end
    hit  = size[1] && slot_ok && (lg != '0);
    keep = ~((32'd1 << lg) - 32'd1);
    if (slot == 3'(ROM_SLOT))
      value = wdata & (keep | 32'd1);
    else
      value = (wdata & keep) | {{(32-TYPE_W){1'b0}}, ty};
  end
endmodule

// File: rtl/cfg_byte_cell.sv
module cfg_byte_cell #(
  parameter logic [7:0] RST_VAL = 8'h00
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       we,
  input  logic [7:0] d,
  output logic [7:0] q
);
  logic [7:0] q_d;

  always_comb q_d = we ? d : q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= RST_VAL;
    else        q <= q_d;
  end
endmodule

// File: rtl/cfg_read_mux.sv
module cfg_read_mux
  import cfgspc_pkg::*;
(
  input  logic [CFG_BYTES*8-1:0] bytes_flat,
  input  logic [7:0]             addr,
  input  logic [1:0]             size,
  output logic [31:0]            data
);
  logic [7:0] a1, a2, a3;
  logic [7:0] b0, b1, b2, b3;

  always_comb begin
    a1 = addr + 8'd1;
    a2 = addr + 8'd2;
    a3 = addr + 8'd3;
    b0 = bytes_flat[{addr, 3'b000} +: 8];
    b1 = bytes_flat[{a1, 3'b000} +: 8];
    b2 = bytes_flat[{a2, 3'b000} +: 8];
    b3 = bytes_flat[{a3, 3'b000} +: 8];
    if (size[1] && addr <= 8'hFC)
      data = {b3, b2, b1, b0};
    else if (size != SZ_BYTE && addr <= 8'hFE)
      data = {16'h0000, b1, b0};
    else
      data = {24'h000000, b0};
  end
endmodule

// File: rtl/cfg_space_regs.sv
module cfg_space_regs
  import cfgspc_pkg::*;
#(
  parameter logic [15:0] VENDOR_ID = 16'h1D0F,
  parameter logic [15:0] DEVICE_ID = 16'h0042,
  parameter logic [31:0] CLASS_REV = 32'h0200_0001,
  parameter logic [7:0]  HDR_TYPE  = 8'h00,
  parameter logic [7:0]  INT_PIN   = 8'h01,
  parameter bit          BRIDGE    = 1'b0,
  parameter logic [NUM_REGIONS*LOG2_W-1:0] REGION_LOG2 =
    {6'd0, 6'd0, 6'd0, 6'd0, 6'd0, 6'd0, 6'd12},
  parameter logic [NUM_REGIONS*TYPE_W-1:0] REGION_TYPE = '0
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        req_valid,
  input  logic        req_write,
  input  logic [7:0]  req_addr,
  input  logic [1:0]  req_size,
  input  logic [31:0] req_wdata,
  output logic [31:0] rd_data,
  output logic [7:0]  sec_bus,
  output logic        map_update
);
  localparam int unsigned HDR_OFS = 14;

  function automatic logic [7:0] reset_byte(input int k);
    logic [7:0] v;
    v = 8'h00;
    case (k)
      0:  v = VENDOR_ID[7:0];
      1:  v = VENDOR_ID[15:8];
      2:  v = DEVICE_ID[7:0];
      3:  v = DEVICE_ID[15:8];
      8:  v = CLASS_REV[7:0];
      9:  v = CLASS_REV[15:8];
      10: v = CLASS_REV[23:16];
      11: v = CLASS_REV[31:24];
      14: v = HDR_TYPE;
      61: v = INT_PIN;
      default: v = 8'h00;
    endcase
    for (int r = 0; r < NUM_BARS; r++) begin
      if (k == 16 + 4*r && REGION_LOG2[r*LOG2_W +: LOG2_W] != '0)
        v = {{(8-TYPE_W){1'b0}}, REGION_TYPE[r*TYPE_W +: TYPE_W]};
    end
    return v;
  endfunction

  logic                  wr_fire, rd_fire;
  logic [2:0]            nbytes;
  logic                  bar_hit;
  logic [31:0]           bar_val;
  logic [CFG_BYTES*8-1:0] bytes_flat;
  logic [7:0]            hdr_q;
  logic [31:0]           mux_data;
  logic [31:0]           rd_d;
  logic                  upd_d;

  always_comb begin
    wr_fire = req_valid && req_write;
    rd_fire = req_valid && !req_write;
    nbytes  = size_bytes(req_size);
    hdr_q   = bytes_flat[HDR_OFS*8 +: 8];
  end

  cfg_bar_mask #(
    .REGION_LOG2(REGION_LOG2),
    .REGION_TYPE(REGION_TYPE)
  ) u_bar_mask (
    .addr (req_addr),
    .size (req_size),
    .wdata(req_wdata),
    .hit  (bar_hit),
    .value(bar_val)
  );

  // one storage cell per configuration byte
  for (genvar k = 0; k < CFG_BYTES; k++) begin : g_byte
    localparam logic [7:0] K = 8'(k);
    logic [7:0]  off;
    logic        in_span;
    logic        we;
    logic [31:0] src;
    logic [7:0]  d;

    always_comb begin
      off     = K - req_addr;
      in_span = (K >= req_addr) && (off < {5'b00000, nbytes});
      we      = wr_fire && in_span && (bar_hit || byte_writable(hdr_q, K));
      src     = bar_hit ? bar_val : req_wdata;
      d       = src[{off[1:0], 3'b000} +: 8];
    end

    cfg_byte_cell #(.RST_VAL(reset_byte(k))) u_cell (
      .clk  (clk),
      .rst_n(rst_n),
      .we   (we),
      .d    (d),
      .q    (bytes_flat[k*8 +: 8])
    );
  end

  cfg_read_mux u_read_mux (
    .bytes_flat(bytes_flat),
    .addr      (req_addr),
    .size      (req_size),
    .data      (mux_data)
  );

  always_comb begin
    rd_d  = rd_fire ? mux_data : rd_data;
    upd_d = wr_fire && (bar_hit ||
            (req_addr < 8'h06 &&
             ({1'b0, req_addr} + {6'b000000, nbytes}) > 9'h004));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_data    <= '0;
      map_update <= 1'b0;
    end else begin
      rd_data    <= rd_d;
      map_update <= upd_d;
    end
  end

  if (BRIDGE) begin : g_bridge
    logic [7:0] sec_d, sec_q;
    always_comb begin
      sec_d = sec_q;
      if (wr_fire) begin
        if (req_addr == 8'h19)
          sec_d = req_wdata[7:0];
        else if (req_addr == 8'h18 && req_size != SZ_BYTE)
          sec_d = req_wdata[15:8];
      end
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sec_q <= 8'h00;
      else        sec_q <= sec_d;
    end
    assign sec_bus = sec_q;
  end else begin : g_endpoint
    assign sec_bus = 8'h00;
  end
endmodule

// File: rtl/cfg_space_chk.sv
module cfg_space_chk #(
  parameter logic [15:0] VENDOR_ID = 16'h0000,
  parameter logic [15:0] DEVICE_ID = 16'h0000
) (
  input logic        clk,
  input logic        rst_n,
  input logic        req_valid,
  input logic        req_write,
  input logic [7:0]  req_addr,
  input logic [1:0]  req_size,
  input logic [31:0] rd_data,
  input logic [7:0]  sec_bus,
  input logic        map_update
);
  // R1: identity dword is always readable at offset 0
  a_r1_identity: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_write && req_addr == 8'h00 && req_size[1])
      |=> rd_data == {DEVICE_ID, VENDOR_ID});

  // R2: read data holds without a read strobe
  a_r2_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !(req_valid && !req_write) |=> $stable(rd_data));

  // R2: last offset always serves a single byte
  a_r2_last_byte: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_write && req_addr == 8'hFF) |=> rd_data[31:8] == 24'h0);

  // R2: offsets 0xFD and 0xFE never return more than two bytes
  a_r2_tail_word: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_write && (req_addr == 8'hFD || req_addr == 8'hFE))
      |=> rd_data[31:16] == 16'h0);

  // R10: update pulse only follows a write
  a_r10_after_write: assert property (@(posedge clk) disable iff (!rst_n)
    map_update |-> $past(req_valid && req_write));

  // R10: a read never requests a window update
  a_r10_not_on_read: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_write) |=> !map_update);

  // R9: secondary bus number moves only after a write
  a_r9_write_only: assert property (@(posedge clk) disable iff (!rst_n)
    (sec_bus != $past(sec_bus)) |-> $past(req_valid && req_write));

  // R9: a byte write at 0x18 leaves the bus number alone
  a_r9_byte18: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_write && req_addr == 8'h18 && req_size == 2'd0)
      |=> $stable(sec_bus));
endmodule

bind cfg_space_regs cfg_space_chk #(
  .VENDOR_ID(VENDOR_ID),
  .DEVICE_ID(DEVICE_ID)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .req_valid (req_valid),
  .req_write (req_write),
  .req_addr  (req_addr),
  .req_size  (req_size),
  .rd_data   (rd_data),
  .sec_bus   (sec_bus),
  .map_update(map_update)
);

// File: tb/cfg_space_regs_bench.sv
module cfg_space_regs_bench;
  // endpoint configuration
  localparam logic [15:0] A_VEN  = 16'h10EC;
  localparam logic [15:0] A_DEV  = 16'h8029;
  localparam logic [31:0] A_CR   = 32'h0200_0003;
  localparam logic [7:0]  A_HDR  = 8'h00;
  localparam logic [7:0]  A_PIN  = 8'h01;
  localparam logic [41:0] A_LOG2 = {6'd11, 6'd0, 6'd0, 6'd20, 6'd0, 6'd12, 6'd5};
  localparam logic [27:0] A_TYPE = {4'h0, 4'h0, 4'h0, 4'h0, 4'h0, 4'h8, 4'h1};
  // bridge configuration
  localparam logic [15:0] B_VEN  = 16'h1B36;
  localparam logic [15:0] B_DEV  = 16'h0001;
  localparam logic [31:0] B_CR   = 32'h0604_0000;
  localparam logic [7:0]  B_HDR  = 8'h81;
  localparam logic [7:0]  B_PIN  = 8'h00;
  localparam logic [41:0] B_LOG2 = {6'd0, 6'd0, 6'd0, 6'd0, 6'd0, 6'd0, 6'd16};
  localparam logic [27:0] B_TYPE = '0;

  logic        clk, rst_n;
  logic        req_valid, req_write;
  logic [7:0]  req_addr;
  logic [1:0]  req_size;
  logic [31:0] req_wdata;
  logic [31:0] rd_a, rd_b;
  logic [7:0]  sec_a, sec_b;
  logic        upd_a, upd_b;

  int checks = 0;
  int fails  = 0;

  logic [7:0] m_a [256];
  logic [7:0] m_b [256];
  logic [7:0] m_sec_b;

  cfg_space_regs #(
    .VENDOR_ID(A_VEN), .DEVICE_ID(A_DEV), .CLASS_REV(A_CR), .HDR_TYPE(A_HDR),
    .INT_PIN(A_PIN), .BRIDGE(1'b0), .REGION_LOG2(A_LOG2), .REGION_TYPE(A_TYPE)
  ) u_cfg_space_regs (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_size(req_size), .req_wdata(req_wdata),
    .rd_data(rd_a), .sec_bus(sec_a), .map_update(upd_a)
  );

  cfg_space_regs #(
    .VENDOR_ID(B_VEN), .DEVICE_ID(B_DEV), .CLASS_REV(B_CR), .HDR_TYPE(B_HDR),
    .INT_PIN(B_PIN), .BRIDGE(1'b1), .REGION_LOG2(B_LOG2), .REGION_TYPE(B_TYPE)
  ) u_cfg_space_regs_bridge (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_size(req_size), .req_wdata(req_wdata),
    .rd_data(rd_b), .sec_bus(sec_b), .map_update(upd_b)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s at %0t: actual=%h expected=%h", tag, $time, act, exp);
    end
  endtask

  // R1 reset image
  function automatic logic [7:0] rst_model(input int which, input int k);
    logic [15:0] ven, dev;
    logic [31:0] cr;
    logic [7:0]  hdr, pin, v;
    logic [41:0] lg;
    logic [27:0] ty;
    ven = which == 0 ? A_VEN : B_VEN;
    dev = which == 0 ? A_DEV : B_DEV;
    cr  = which == 0 ? A_CR  : B_CR;
    hdr = which == 0 ? A_HDR : B_HDR;
    pin = which == 0 ? A_PIN : B_PIN;
    lg  = which == 0 ? A_LOG2 : B_LOG2;
    ty  = which == 0 ? A_TYPE : B_TYPE;
    v = 8'h00;
    if (k < 2) v = ven[8*k +: 8];
    else if (k < 4) v = dev[8*(k-2) +: 8];
    else if (k >= 8 && k < 12) v = cr[8*(k-8) +: 8];
    else if (k == 14) v = hdr;
    else if (k == 61) v = pin;
    else if (k >= 16 && k < 40 && k % 4 == 0 && lg[((k-16)/4)*6 +: 6] != 6'd0)
      v = {4'h0, ty[((k-16)/4)*4 +: 4]};
    return v;
  endfunction

  // R3 / R4 protection maps
  function automatic bit locked(input logic [7:0] hdr, input int a);
    bit common;
    common = (a < 4) || (a >= 8 && a < 12) || a == 14 || a == 61;
    if (hdr == 8'h00 || hdr == 8'h80) return common || (a >= 16 && a < 40) || (a >= 48 && a < 52);
    return common || (a >= 56 && a < 60);
  endfunction

  task automatic set_byte(input int which, input int a, input logic [7:0] d);
    if (which == 0) m_a[a] = d;
    else            m_b[a] = d;
  endtask

  task automatic model_write(input int which, input int a, input int sz,
                             input logic [31:0] v, output bit upd);
    logic [41:0] lg;
    logic [27:0] ty;
    logic [7:0]  hdr;
    logic [31:0] keep, mv;
    int n, slot, lgv;
    lg  = which == 0 ? A_LOG2 : B_LOG2;
    ty  = which == 0 ? A_TYPE : B_TYPE;
    hdr = which == 0 ? m_a[14] : m_b[14];
    n   = (sz == 0) ? 1 : (sz == 1) ? 2 : 4;
    slot = -1;
    if (sz >= 2 && a % 4 == 0) begin
      if (a >= 16 && a <= 36) slot = (a - 16) / 4;
      else if (a == 48) slot = 6;
    end
    lgv = (slot >= 0) ? int'(lg[slot*6 +: 6]) : 0;
    upd = 1'b0;
    if (lgv != 0) begin
      keep = ~((32'd1 << lgv) - 32'd1);
      if (slot == 6) mv = v & (keep | 32'd1);
      else           mv = (v & keep) | {28'h0, ty[slot*4 +: 4]};
      for (int i = 0; i < 4; i++) set_byte(which, a + i, mv[8*i +: 8]);
      upd = 1'b1;
    end else begin
      for (int i = 0; i < n; i++)
        if (a + i <= 255 && !locked(hdr, a + i)) set_byte(which, a + i, v[8*i +: 8]);
      if (a < 6 && a + n > 4) upd = 1'b1;
    end
    if (which == 1) begin
      if (a == 25) m_sec_b = v[7:0];
      else if (a == 24 && sz != 0) m_sec_b = v[15:8];
    end
  endtask

  function automatic logic [31:0] exp_read(input int which, input int a, input int sz);
    logic [31:0] r;
    int n;
    if (sz >= 2 && a <= 252) n = 4;
    else if (sz >= 1 && a <= 254) n = 2;
    else n = 1;
    r = '0;
    for (int i = 0; i < n; i++)
      r[8*i +: 8] = (which == 0) ? m_a[a + i] : m_b[a + i];
    return r;
  endfunction

  task automatic do_write(input int a, input int sz, input logic [31:0] v);
    bit ua, ub;
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b1; req_addr = 8'(a); req_size = 2'(sz); req_wdata = v;
    @(negedge clk);
    req_valid = 1'b0; req_write = 1'b0;
    model_write(0, a, sz, v, ua);
    model_write(1, a, sz, v, ub);
    check("R10 endpoint update pulse", {31'h0, upd_a}, {31'h0, ua});
    check("R10 bridge update pulse",   {31'h0, upd_b}, {31'h0, ub});
    check("R9 bridge secondary bus",   {24'h0, sec_b}, {24'h0, m_sec_b});
    check("R9 endpoint bus stays 0",   {24'h0, sec_a}, 32'h0);
  endtask

  task automatic do_read(input int a, input int sz, input string tag_a, input string tag_b);
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b0; req_addr = 8'(a); req_size = 2'(sz);
    @(negedge clk);
    req_valid = 1'b0;
    check(tag_a, rd_a, exp_read(0, a, sz));
    check(tag_b, rd_b, exp_read(1, a, sz));
    check("R10 no pulse after read", {31'h0, upd_a | upd_b}, 32'h0);
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin : stimulus
    rst_n = 1'b0; req_valid = 1'b0; req_write = 1'b0;
    req_addr = '0; req_size = '0; req_wdata = '0;
    for (int k = 0; k < 256; k++) begin
      m_a[k] = rst_model(0, k);
      m_b[k] = rst_model(1, k);
    end
    m_sec_b = 8'h00;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1: outputs and whole image after reset
    check("R1 update low after reset", {31'h0, upd_a | upd_b}, 32'h0);
    check("R1 sec bus after reset", {24'h0, sec_b}, 32'h0);
    for (int a = 0; a < 256; a++) do_read(a, 0, "R1 endpoint reset byte", "R1 bridge reset byte");
    do_read(0, 2, "R1 endpoint identity dword", "R1 bridge identity dword");

    // R2: every size at the tail and near the start
    for (int a = 240; a < 256; a++) do_write(a, 0, 32'(a * 7 + 3));
    for (int sz = 0; sz < 4; sz++) begin
      for (int a = 240; a < 256; a++) do_read(a, sz, "R2 endpoint tail read", "R2 bridge tail read");
      for (int a = 0; a < 16; a++) do_read(a, sz, "R2 endpoint head read", "R2 bridge head read");
    end

    // R3 / R4: byte-write sweep over every offset
    for (int a = 0; a < 256; a++) begin
      do_write(a, 0, 32'(a ^ 8'hC3) | 32'h0000_0100);
      do_read(a, 0, "R3 endpoint protection", "R4 bridge protection");
    end

    // R5 / R6 / R7: dword writes at every base and ROM slot
    for (int s = 0; s < 7; s++) begin
      int ofs;
      ofs = (s == 6) ? 48 : 16 + 4*s;
      do_write(ofs, 2, 32'hFFFF_FFFF);
      do_read(ofs, 2, "R5 R6 R7 endpoint slot all-ones", "R5 R7 bridge slot all-ones");
      do_write(ofs, 3, 32'h1234_5679);
      do_read(ofs, 2, "R5 R6 R7 endpoint slot pattern", "R5 R7 bridge slot pattern");
      do_write(ofs, 2, 32'h8000_0A00);
      do_read(ofs, 2, "R6 R5 endpoint enable clear", "R7 bridge enable clear");
    end

    // R11: unaligned dwords in the base and ROM range
    do_write(17, 2, 32'hDEAD_BEEF);
    do_read(16, 2, "R11 endpoint unaligned base", "R11 bridge unaligned base");
    do_read(20, 2, "R11 endpoint unaligned spill", "R11 bridge unaligned spill");
    do_write(50, 2, 32'hCAFE_F00D);
    do_read(48, 2, "R11 endpoint unaligned rom", "R11 bridge unaligned rom");
    do_read(52, 2, "R11 endpoint unaligned rom spill", "R11 bridge unaligned rom spill");

    // R8: multi-byte writes that run off the end
    do_write(253, 2, 32'hA1B2_C3D4);
    do_read(252, 2, "R8 endpoint clipped dword", "R8 bridge clipped dword");
    do_write(255, 1, 32'h0000_5566);
    do_read(254, 1, "R8 endpoint clipped word", "R8 bridge clipped word");
    do_write(254, 3, 32'h0102_0304);
    do_read(252, 2, "R8 endpoint clipped at FE", "R8 bridge clipped at FE");
    do_read(0, 2, "R8 endpoint no wrap", "R8 bridge no wrap");
    do_write(64, 2, 32'h4433_2211);
    do_read(64, 2, "R8 endpoint byte order", "R8 bridge byte order");

    // R9: secondary bus capture
    do_write(25, 0, 32'h0000_0042);
    do_write(24, 1, 32'h0000_3711);
    do_write(24, 2, 32'hAABB_99CC);
    do_write(24, 0, 32'h0000_0077);
    do_write(23, 2, 32'h5555_5555);
    do_write(25, 1, 32'h0000_1234);
    do_read(24, 2, "R9 endpoint bus bytes", "R9 bridge bus bytes");

    // R10: command-word coverage
    do_write(3, 1, 32'h0000_0700);
    do_write(6, 1, 32'h0000_FFFF);
    do_write(5, 0, 32'h0000_0001);
    do_write(60, 2, 32'h0000_010B);
    do_write(2, 2, 32'h0000_0000);
    do_read(4, 1, "R10 endpoint command", "R10 bridge command");

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule